// File: doc/BRIEF.md
# Serial EEPROM Boot Copier

After reset this block works as the only master on a two-wire serial bus. It copies a fixed-length block from an external serial EEPROM into a local memory write port, starting at EEPROM address zero. It drives two open-drain pins, called A and B, and never drives either pin high. The EEPROM's capacity is never configured. The block works it out from the way the board wires the pins. A part with a one-byte word address uses pin A as clock and pin B as data. A part with a two-byte word address uses pin A as data and pin B as clock.

The block first probes under the two-byte wiring by sending a device-select write byte (0xA0). If that byte is not acknowledged, it issues a STOP, swaps the pin roles, and probes again under the one-byte wiring. Once a probe is acknowledged, it sends the word address 0x0000, either as two zero bytes (high byte first) or as one zero byte. For the one-byte part, the upper address bits travel in bits 3:1 of the device-select byte, and they are zero here. It then issues a repeated START and sends 0xA1. It reads the bytes in sequence, acknowledging every byte except the last, which gets a NACK and a STOP. Each byte received is written to the memory port at the next address. When the copy finishes, a done flag stays high. If neither probe is acknowledged, an error flag stays high and both pins are left released.

Top module: `eeprom_boot_loader`

## Requirements
- R1: While reset is held and just after it is released, both pin enables are low (pins released), and done, error and memWe are low.
- R2: The first pin driven low after reset is pin A, with pin B still released: a START under the two-byte wiring (A data, B clock).
- R3: If the two-byte probe gets no acknowledge, the block retries under the one-byte wiring (A clock, B data). A one-byte part is then reported with sizeLarge = 0 at done.
- R4: A part that acknowledges the two-byte probe is reported with sizeLarge = 1. It receives exactly two word-address bytes, both 0x00, so reading starts at address 0.
- R5: A one-byte part receives the write device-select 0xA0 and exactly one word-address byte, 0x00.
- R6: The block issues exactly LOAD_BYTES memory writes, at addresses 0, 1, 2 … in order. Each write carries the EEPROM byte at that same address.
- R7: Every read byte except the last is acknowledged. The last byte gets a NACK and is followed by a STOP, and both pins are released while done is high.
- R8: If neither probe is acknowledged, error rises, done stays low, no memory write occurs, and both pins stay released.
- R9: Inside a byte, successive clock rising edges are exactly 4*(SYS_CLK_HZ/(4*SCL_HZ)) system cycles apart. With the default values this gives 100 kHz.
- R10: Done and error never assert together. Each stays set once it is set, and no memory write occurs after either is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinAIn | input | 1 | Level seen on pin A |
| pinBIn | input | 1 | Level seen on pin B |
| pinAOe | output | 1 | 1 pulls pin A low, 0 releases it |
| pinBOe | output | 1 | 1 pulls pin B low, 0 releases it |
| memWe | output | 1 | One-cycle write strobe to local memory |
| memAddr | output | 16 | Local memory write address |
| memData | output | 8 | Local memory write data |
| done | output | 1 | Copy complete (sticky) |
| error | output | 1 | No EEPROM answered (sticky) |
| sizeLarge | output | 1 | 1 = two-byte address part detected |

## Verification
The bench attaches an EEPROM model that follows only one wiring at a time. A design that probed the one-byte wiring first, or that failed to swap pin roles on fallback, would stall or raise error against the matching part. The model also counts the word-address bytes it receives and records which read byte got a NACK. A design that sent the wrong number of address bytes for a size, or acknowledged the final byte, would show up as an off-by-one count. With no part attached, the bench expects error, no writes and released pins. It also measures clock spacing inside every byte, so a bit timer that slips a cycle on phase changes is caught.

// File: rtl/eeprom_boot_pkg.sv
package eeprom_boot_pkg;
  localparam int ADDR_W = 16;
  localparam logic [6:0] DEV_ID = 7'h50;

  typedef enum logic [1:0] {OP_START, OP_STOP, OP_WRITE, OP_READ} busOp_e;

  typedef struct packed {
    logic   go;
    busOp_e op;
    logic [7:0] txByte;
    logic   nackLast;
    logic   useLarge;
  } busCmd_t;
endpackage

// File: rtl/eeprom_boot_dp.sv
module eeprom_boot_dp
  import eeprom_boot_pkg::*;
#(
  parameter int QUARTER = 125
) (
  input  logic       clk,
  input  logic       rstN,
  input  busCmd_t    cmd,
  input  logic       pinAIn,
  input  logic       pinBIn,
  output logic       pinAOe,
  output logic       pinBOe,
  output logic       opDone,
  output logic       ackSeen,
  output logic [7:0] rxByte
);
  localparam int DIV_W = (QUARTER > 1) ? $clog2(QUARTER) : 1;

  logic [DIV_W-1:0] divCnt;
  logic       busy, tick;
  busOp_e     curOp;
  logic [1:0] phase;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg;
  logic       nackReg, ackReg;
  logic       sclLvl, sdaLvl, nextScl, nextSda;
  logic [1:0] syncA, syncB;
  logic       sdaIn;

  assign tick  = busy && (divCnt == DIV_W'(QUARTER - 1));
  assign sdaIn = cmd.useLarge ? syncA[1] : syncB[1];

  // Line levels for the current quarter of the current bit
  always_comb begin
    nextScl = sclLvl;
    nextSda = sdaLvl;
    unique case (curOp)
      OP_START: begin
        nextSda = (phase < 2'd2);
        nextScl = (phase == 2'd0) ? sclLvl : (phase != 2'd3);
      end
      OP_STOP: begin
        nextSda = (phase >= 2'd2);
        nextScl = (phase != 2'd0);
      end
      OP_WRITE: begin
        nextSda = (bitCnt == 4'd8) ? 1'b1 : shiftReg[7];
        nextScl = (phase == 2'd1) || (phase == 2'd2);
      end
      OP_READ: begin
        nextSda = (bitCnt == 4'd8) ? nackReg : 1'b1;
        nextScl = (phase == 2'd1) || (phase == 2'd2);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0; busy <= 1'b0; curOp <= OP_START; phase <= '0;
      bitCnt <= '0; shiftReg <= '0; nackReg <= 1'b0; ackReg <= 1'b1;
      sclLvl <= 1'b1; sdaLvl <= 1'b1; opDone <= 1'b0;
      syncA <= 2'b11; syncB <= 2'b11;
    end else begin
      syncA  <= {syncA[0], pinAIn};
      syncB  <= {syncB[0], pinBIn};
      opDone <= 1'b0;
      divCnt <= (!busy || tick) ? '0 : divCnt + 1'b1;
      if (busy) begin
        sclLvl <= nextScl;
        sdaLvl <= nextSda;
      end
      if (cmd.go && !busy) begin
        busy     <= 1'b1;
        curOp    <= cmd.op;
        phase    <= '0;
        bitCnt   <= '0;
        shiftReg <= cmd.txByte;
        nackReg  <= cmd.nackLast;
      end else if (tick) begin
        phase <= phase + 2'd1;
        if (phase == 2'd1) begin
          if (curOp == OP_WRITE && bitCnt == 4'd8) ackReg <= sdaIn;
          if (curOp == OP_READ && bitCnt != 4'd8) shiftReg <= {shiftReg[6:0], sdaIn};
        end
        if (phase == 2'd3) begin
          if (curOp == OP_WRITE && bitCnt != 4'd8) shiftReg <= {shiftReg[6:0], 1'b0};
          if (curOp == OP_START || curOp == OP_STOP || bitCnt == 4'd8) begin
            busy   <= 1'b0;
            opDone <= 1'b1;
          end else begin
            bitCnt <= bitCnt + 4'd1;
          end
        end
      end
    end
  end

  assign pinAOe  = cmd.useLarge ? ~sdaLvl : ~sclLvl;
  assign pinBOe  = cmd.useLarge ? ~sclLvl : ~sdaLvl;
  assign ackSeen = ~ackReg;
  assign rxByte  = shiftReg;
endmodule

// File: rtl/eeprom_boot_ctrl.sv
module eeprom_boot_ctrl
  import eeprom_boot_pkg::*;
#(
  parameter int LOAD_BYTES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opDone,
  input  logic              ackSeen,
  input  logic [7:0]        rxByte,
  output busCmd_t           cmd,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic              done,
  output logic              error,
  output logic              sizeLarge
);
  typedef enum logic [3:0] {
    S_PRB_START, S_PRB_DEV, S_PRB_STOP, S_ALT_START, S_ALT_DEV,
    S_ADDR_HI, S_ADDR_LO, S_RE_START, S_RD_DEV, S_RD_BYTE,
    S_FIN_STOP, S_ERR_STOP, S_DONE, S_ERROR
  } state_e;

  state_e state;
  logic   issued, useLarge, lastByte;
  logic [ADDR_W-1:0] cnt;

  assign lastByte = (cnt == ADDR_W'(LOAD_BYTES - 1));

  always_comb begin
    cmd.go       = !issued && (state != S_DONE) && (state != S_ERROR);
    cmd.useLarge = useLarge;
    cmd.nackLast = lastByte;
    cmd.txByte   = 8'h00;
    cmd.op       = OP_START;
    unique case (state)
      S_PRB_STOP, S_FIN_STOP, S_ERR_STOP: cmd.op = OP_STOP;
      S_PRB_DEV, S_ALT_DEV: begin cmd.op = OP_WRITE; cmd.txByte = {DEV_ID, 1'b0}; end
      S_ADDR_HI, S_ADDR_LO: cmd.op = OP_WRITE;
      S_RD_DEV:  begin cmd.op = OP_WRITE; cmd.txByte = {DEV_ID, 1'b1}; end
      S_RD_BYTE: cmd.op = OP_READ;
      default:   cmd.op = OP_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_PRB_START; issued <= 1'b0; useLarge <= 1'b1;
      cnt <= '0; memWe <= 1'b0; memAddr <= '0; memData <= '0;
    end else begin
      memWe <= 1'b0;
      if (cmd.go) issued <= 1'b1;
      if (opDone) begin
        issued <= 1'b0;
        unique case (state)
          S_PRB_START: state <= S_PRB_DEV;
          S_PRB_DEV:   state <= ackSeen ? S_ADDR_HI : S_PRB_STOP;
          S_PRB_STOP:  begin useLarge <= 1'b0; state <= S_ALT_START; end
          S_ALT_START: state <= S_ALT_DEV;
          S_ALT_DEV:   state <= ackSeen ? S_ADDR_LO : S_ERR_STOP;
          S_ADDR_HI:   state <= ackSeen ? S_ADDR_LO : S_ERR_STOP;
          S_ADDR_LO:   state <= ackSeen ? S_RE_START : S_ERR_STOP;
          S_RE_START:  state <= S_RD_DEV;
          S_RD_DEV:    state <= ackSeen ? S_RD_BYTE : S_ERR_STOP;
          S_RD_BYTE: begin
            memWe   <= 1'b1;
            memAddr <= cnt;
            memData <= rxByte;
            if (lastByte) state <= S_FIN_STOP;
            else          cnt   <= cnt + 1'b1;
          end
          S_FIN_STOP:  state <= S_DONE;
          S_ERR_STOP:  state <= S_ERROR;
          default:     state <= state;
        endcase
      end
    end
  end

  assign done      = (state == S_DONE);
  assign error     = (state == S_ERROR);
  assign sizeLarge = useLarge;
endmodule

// File: rtl/eeprom_boot_loader.sv
module eeprom_boot_loader
  import eeprom_boot_pkg::*;
#(
  parameter int SYS_CLK_HZ = 50_000_000,
  parameter int SCL_HZ     = 100_000,
  parameter int LOAD_BYTES = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinAIn,
  input  logic        pinBIn,
  output logic        pinAOe,
  output logic        pinBOe,
  output logic        memWe,
  output logic [15:0] memAddr,
  output logic [7:0]  memData,
  output logic        done,
  output logic        error,
  output logic        sizeLarge
);
  localparam int QUARTER = SYS_CLK_HZ / (4 * SCL_HZ);

  busCmd_t    cmd;
  logic       opDone, ackSeen;
  logic [7:0] rxByte;

  eeprom_boot_ctrl #(.LOAD_BYTES(LOAD_BYTES)) i_ctrl (
    .clk(clk), .rstN(rstN), .opDone(opDone), .ackSeen(ackSeen), .rxByte(rxByte),
    .cmd(cmd), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .done(done), .error(error), .sizeLarge(sizeLarge)
  );

  eeprom_boot_dp #(.QUARTER(QUARTER)) i_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .pinAIn(pinAIn), .pinBIn(pinBIn),
    .pinAOe(pinAOe), .pinBOe(pinBOe), .opDone(opDone), .ackSeen(ackSeen),
    .rxByte(rxByte)
  );
endmodule

// File: rtl/eeprom_boot_checker.sv
module eeprom_boot_checker #(
  parameter int LOAD_BYTES = 256
) (
  input logic        clk,
  input logic        rstN,
  input logic        pinAOe,
  input logic        pinBOe,
  input logic        memWe,
  input logic [15:0] memAddr,
  input logic        done,
  input logic        error,
  input logic        sizeLarge
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN) !(done && error)); // R10
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN) done |=> done); // R10
  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rstN) error |=> error); // R10
  AST_NO_LATE_WRITE: assert property (@(posedge clk) disable iff (!rstN) memWe |-> !done && !error); // R10
  AST_ERROR_RELEASED: assert property (@(posedge clk) disable iff (!rstN) error |-> !pinAOe && !pinBOe); // R8
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rstN) done |-> !pinAOe && !pinBOe); // R7
  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN) memWe |-> (32'(memAddr) < LOAD_BYTES)); // R6
  AST_SIZE_HELD: assert property (@(posedge clk) disable iff (!rstN) done |=> $stable(sizeLarge)); // R4
endmodule

bind eeprom_boot_loader eeprom_boot_checker #(.LOAD_BYTES(LOAD_BYTES)) i_checker (
  .clk(clk), .rstN(rstN), .pinAOe(pinAOe), .pinBOe(pinBOe), .memWe(memWe),
  .memAddr(memAddr), .done(done), .error(error), .sizeLarge(sizeLarge)
);

// File: tb/test_eeprom_boot_loader.sv
module test_eeprom_boot_loader;
  localparam int SYS_HZ = 1_600_000;
  localparam int SCL_HZ = 100_000;
  localparam int LOAD   = 6;
  localparam int BITP   = 4 * (SYS_HZ / (4 * SCL_HZ));

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic pinAOe, pinBOe, memWe, done, error, sizeLarge;
  logic [15:0] memAddr;
  logic [7:0]  memData;
  logic busA, busB, drvSda;
  int   slvMode = 0; // 0 none, 1 one-byte part, 2 two-byte part

  assign busA = !(pinAOe || (slvMode == 2 && drvSda));
  assign busB = !(pinBOe || (slvMode == 1 && drvSda));

  eeprom_boot_loader #(.SYS_CLK_HZ(SYS_HZ), .SCL_HZ(SCL_HZ), .LOAD_BYTES(LOAD)) i_eeprom_boot_loader (
    .clk(clk), .rstN(rstN), .pinAIn(busA), .pinBIn(busB), .pinAOe(pinAOe), .pinBOe(pinBOe),
    .memWe(memWe), .memAddr(memAddr), .memData(memData), .done(done), .error(error),
    .sizeLarge(sizeLarge)
  );

  int checks = 0, errors = 0;

  function automatic logic [7:0] romByte(int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // EEPROM model and monitors, all at the falling system edge
  typedef enum int {M_IDLE, M_RX, M_ACKW, M_TX, M_ACKR} mst_e;
  mst_e mst;
  int cyc, lastRise, cnt, byteNum, addrBytes, readBytes, acks, nackAt, stops, periodChecks, periodBad;
  int writes, orderBad, dataBad, devWrite, startPtr;
  bit prevScl, prevSda, isRead, sel, mNack, firstSeen, firstA;
  logic [7:0]  rx, txb;
  logic [15:0] ptr;
  logic [2:0]  ptrHi;

  always @(negedge clk) begin
    bit scl, sda;
    cyc++;
    scl = (slvMode == 2) ? busB : busA;
    sda = (slvMode == 2) ? busA : busB;
    if (!rstN) begin
      mst = M_IDLE; drvSda = 0; cnt = 0; byteNum = 0; addrBytes = 0; readBytes = 0;
      acks = 0; nackAt = -1; stops = 0; periodChecks = 0; periodBad = 0; writes = 0;
      orderBad = 0; dataBad = 0; devWrite = -1; startPtr = -1; sel = 0; ptr = 0; ptrHi = 0;
      firstSeen = 0; firstA = 0; prevScl = 1; prevSda = 1; lastRise = 0; isRead = 0;
    end else begin
      if (!firstSeen && (pinAOe || pinBOe)) begin firstSeen = 1; firstA = pinAOe && !pinBOe; end
      if (memWe) begin
        if (32'(memAddr) != writes) orderBad++;
        if (memData != romByte(int'(memAddr))) dataBad++;
        writes++;
      end
      if (slvMode != 0) begin
        if (prevScl && scl && prevSda && !sda) begin
          mst = M_RX; cnt = 0; byteNum = 0; drvSda = 0; sel = 0;
        end else if (prevScl && scl && !prevSda && sda) begin
          mst = M_IDLE; drvSda = 0; stops++;
        end else if (!prevScl && scl) begin
          if (sel && ((mst == M_RX && cnt > 0) || (mst == M_TX && cnt > 0))) begin
            periodChecks++;
            if (cyc - lastRise != BITP) periodBad++;
          end
          lastRise = cyc;
          if (mst == M_RX) begin rx = {rx[6:0], sda}; cnt++; end
          else if (mst == M_TX) cnt++;
          else if (mst == M_ACKR) mNack = sda;
        end else if (prevScl && !scl) begin
          case (mst)
            M_RX: if (cnt == 8) begin
              if (byteNum == 0) begin
                if ((slvMode == 2 && rx[7:1] == 7'h50) || (slvMode == 1 && rx[7:4] == 4'hA)) begin
                  isRead = rx[0]; sel = 1; drvSda = 1; mst = M_ACKW;
                  if (slvMode == 1) ptrHi = rx[3:1];
                  if (!isRead && devWrite < 0) devWrite = rx;
                  if (isRead) startPtr = ptr;
                end else mst = M_IDLE;
              end else begin
                if (slvMode == 2) begin
                  if (byteNum == 1) ptr[15:8] = rx; else ptr[7:0] = rx;
                end else ptr = {5'd0, ptrHi, rx};
                addrBytes++; drvSda = 1; mst = M_ACKW;
              end
              byteNum++;
            end
            M_ACKW: begin
              cnt = 0;
              if (isRead) begin txb = romByte(int'(ptr)); drvSda = !txb[7]; mst = M_TX; end
              else begin drvSda = 0; mst = M_RX; end
            end
            M_TX: if (cnt == 8) begin drvSda = 0; mst = M_ACKR; end
                  else drvSda = !txb[7 - cnt];
            M_ACKR: begin
              readBytes++;
              if (mNack) begin nackAt = readBytes; mst = M_IDLE; drvSda = 0; end
              else begin
                acks++; ptr++; cnt = 0; txb = romByte(int'(ptr)); drvSda = !txb[7]; mst = M_TX;
              end
            end
            default: ;
          endcase
        end
      end
      prevScl = scl; prevSda = sda;
    end
  end

  task automatic runBoot(int mode, output bit finished);
    slvMode = mode;
    rstN = 0;
    repeat (5) @(negedge clk);
    rstN = 1;
    finished = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done || error) begin finished = 1; break; end
    end
    check(finished, "R10", "boot finished within limit", int'(finished), 1);
    repeat (200) @(negedge clk);
  endtask

  task automatic testReset();
    slvMode = 0;
    rstN = 0;
    repeat (4) @(negedge clk);
    check(!pinAOe && !pinBOe, "R1", "pins released in reset", {pinAOe, pinBOe}, 0);
    check(!done && !error && !memWe, "R1", "flags low in reset", {done, error, memWe}, 0);
    rstN = 1;
    @(negedge clk);
    check(!pinAOe && !pinBOe && !done && !error, "R1", "idle right after reset",
          {pinAOe, pinBOe, done, error}, 0);
  endtask

  task automatic testOneByte();
    bit fin;
    runBoot(1, fin);
    check(firstA, "R2", "first low pin is A", int'(firstA), 1);
    check(done && !error, "R3", "done with one-byte part", {done, error}, 2);
    check(sizeLarge == 0, "R3", "sizeLarge one-byte", int'(sizeLarge), 0);
    check(devWrite == 8'hA0, "R5", "write device select", devWrite, 8'hA0);
    check(addrBytes == 1, "R5", "address byte count", addrBytes, 1);
    check(startPtr == 0, "R5", "start pointer", startPtr, 0);
    check(writes == LOAD, "R6", "write count", writes, LOAD);
    check(orderBad == 0 && dataBad == 0, "R6", "write order and data", orderBad + dataBad, 0);
    check(nackAt == LOAD, "R7", "NACK position", nackAt, LOAD);
    check(acks == LOAD - 1, "R7", "ACK count", acks, LOAD - 1);
    check(stops >= 1 && !pinAOe && !pinBOe, "R7", "stop and released", stops, 1);
    check(periodChecks > 0 && periodBad == 0, "R9", "clock period", periodBad, 0);
    check(done && !error && writes == LOAD, "R10", "done held, no late writes", writes, LOAD);
  endtask

  task automatic testTwoByte();
    bit fin;
    runBoot(2, fin);
    check(firstA, "R2", "first low pin is A", int'(firstA), 1);
    check(done && sizeLarge, "R4", "sizeLarge two-byte", int'(sizeLarge), 1);
    check(addrBytes == 2, "R4", "address byte count", addrBytes, 2);
    check(startPtr == 0, "R4", "start pointer", startPtr, 0);
    check(writes == LOAD && orderBad == 0 && dataBad == 0, "R6", "copied block", writes, LOAD);
    check(nackAt == LOAD && acks == LOAD - 1, "R7", "NACK only on last", nackAt, LOAD);
    check(!pinAOe && !pinBOe, "R7", "released after done", {pinAOe, pinBOe}, 0);
    check(periodChecks > 0 && periodBad == 0, "R9", "clock period", periodBad, 0);
  endtask

  task automatic testAbsent();
    bit fin;
    runBoot(0, fin);
    check(firstA, "R2", "first low pin is A", int'(firstA), 1);
    check(error && !done, "R8", "error without part", {error, done}, 2);
    check(writes == 0, "R8", "no memory writes", writes, 0);
    check(!pinAOe && !pinBOe, "R8", "pins released on error", {pinAOe, pinBOe}, 0);
  endtask

  initial begin
    #(8 * 190000);
    check(0, "R10", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testOneByte();
    testTwoByte();
    testAbsent();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule